// File: doc/BRIEF.md
# Prioritised Interrupt Group Vector Controller

This block gathers up to sixteen peripheral event lines into one interrupt group with a fixed priority order. Each event pulse latches a sticky pending bit. A mask register selects which pending bits may raise the group's single request line to the CPU. A read-only vector location reports which enabled pending source has the highest priority.

When the CPU reads the vector location, that source's pending bit is cleared in the same access. The clear is hazard-free. The vector value comes straight from the flags and mask of the read cycle, and only the flag named by the returned code is cleared. An event that lands in the same cycle as the read, including one of higher priority, is therefore kept. After each vector read the request line drops for one cycle, so any source still pending shows up as a fresh request.

Software reaches the block through a single-cycle register port. Every access is acknowledged one cycle later, and no access ever stalls that acknowledge. Pending bits are cleared by writing ones to them.

Top module: `irq_group_ctrl`

## Requirements
- R1: After synchronous reset, all pending bits, the mask, the read data, the acknowledge and the request line are 0, and a vector read returns 0.
- R2: A one-cycle pulse on event line i sets pending bit i at the next clock edge, and the bit stays set until cleared. Pending bits read back at address 0, with bit i in data bit i.
- R3: Writing to address 0 clears every pending bit whose data bit is 1 and leaves the bits written with 0 unchanged. Writing FFFFh clears all pending bits.
- R4: If an event and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R5: The mask is read and written at address 1, with bit i enabling source i. The request line is 1 exactly when some pending bit and its mask bit are both 1, except in the cycle after a vector read. Masked sources never appear in the vector.
- R6: A vector read is a read at address 2. It returns 0 when no enabled source is pending. Otherwise it returns i+1 for the enabled pending source with the lowest index i, since the lowest index has the highest priority.
- R7: A vector read clears only the pending bit of the source it returns. A read that returns 0 clears nothing.
- R8: An event that arrives in the same cycle as a vector read is never lost. This holds even when it has higher priority than the returned source, and in that case the returned code is still that of the lower-priority source.
- R9: In the cycle after a vector read the request line is 0. One cycle later it is 1 again if an enabled source is still pending.
- R10: A write to address 2 changes neither the vector, the pending bits nor the mask.
- R11: Every access, read or write at any address, is acknowledged by a one-cycle pulse in the following cycle. Read data is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_SRC | Event pulses, one per source |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register select: 0 pending, 1 mask, 2 vector |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_ack | output | 1 | Access acknowledge, one cycle after bus_en |
| irq_o | output | 1 | Registered interrupt request to the CPU |

## Verification
The bench builds the block with its defaults: NUM_SRC equal to DATA_W, both 16. This makes the full pending register visible. An all-ones clear can then reach every bit, and both the highest-priority source (index 0) and the lowest (index 15, code 16) can be driven through the vector path. With all sixteen sources present, the bench can also place a higher-priority event in the exact cycle of a lower-priority vector read, and combine a masked lower index with an enabled higher one.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;

  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_MASK = 2'd1,
    REG_VEC  = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] w1c,
  input  logic [N-1:0] vec_clr,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] flag_d
);

  // set wins over any clear in the same cycle
  always_comb flag_d = (flag_q & ~(w1c | vec_clr)) | evt;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= flag_d;
  end

  // R2 R4 R8: an event always leaves its flag set
  p_event_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((flag_q & $past(evt)) == $past(evt)));

  // R3: written ones clear unless a new event lands
  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (|w1c) |=> ((flag_q & $past(w1c) & ~$past(evt)) == '0));

  // R7: a vector read clears at most one source
  p_single_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vec_clr));

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N     = 16,
  parameter int VEC_W = 5
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [VEC_W-1:0] code
);

  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]     = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code = code | VEC_W'(i + 1);
    end
  end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_grp_pkg::*;
#(
  parameter int N      = 16,
  parameter int DATA_W = 16,
  parameter int VEC_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N-1:0]      flag_q,
  input  logic [VEC_W-1:0]  vec_code,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      mask_d,
  output logic [N-1:0]      w1c,
  output logic              vec_rd,
  output logic [DATA_W-1:0] rdata,
  output logic              ack
);

  reg_sel_e sel;
  logic     wr_en, rd_en;

  always_comb begin
    sel    = reg_sel_e'(bus_addr);
    wr_en  = bus_en & bus_we;
    rd_en  = bus_en & ~bus_we;
    w1c    = (wr_en && sel == REG_PEND) ? bus_wdata[N-1:0] : '0;
    vec_rd = rd_en && sel == REG_VEC;
    mask_d = (wr_en && sel == REG_MASK) ? bus_wdata[N-1:0] : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      rdata  <= '0;
      ack    <= 1'b0;
    end else begin
      mask_q <= mask_d;
      ack    <= bus_en;
      if (rd_en) begin
        unique case (sel)
          REG_PEND: rdata <= DATA_W'(flag_q);
          REG_MASK: rdata <= DATA_W'(mask_q);
          REG_VEC:  rdata <= DATA_W'(vec_code);
          default:  rdata <= '0;
        endcase
      end
    end
  end

  // R11: each access is acknowledged in the next cycle
  p_ack_next_r11: assert property (@(posedge clk) disable iff (rst)
    bus_en |=> ack);

  // R10: a write to the vector address leaves the mask alone
  p_vec_write_inert_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == REG_VEC) |=> (mask_q == $past(mask_q)));

endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl #(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [1:0]         bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_ack,
  output logic               irq_o
);

  localparam int VEC_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC-1:0] flag_q, flag_d, mask_q, mask_d, w1c, grant, vec_clr, enabled;
  logic [VEC_W-1:0]   vec_code;
  logic               vec_rd;
  logic               irq_q;

  irq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst(rst), .evt(evt_i), .w1c(w1c), .vec_clr(vec_clr),
    .flag_q(flag_q), .flag_d(flag_d)
  );

  assign enabled = flag_q & mask_q;

  irq_prio_enc #(.N(NUM_SRC), .VEC_W(VEC_W)) u_enc (
    .req(enabled), .grant(grant), .code(vec_code)
  );

  // only the granted source, from the same cycle's flags, is cleared
  assign vec_clr = grant & {NUM_SRC{vec_rd}};

  irq_regs #(.N(NUM_SRC), .DATA_W(DATA_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flag_q(flag_q),
    .vec_code(vec_code), .mask_q(mask_q), .mask_d(mask_d), .w1c(w1c),
    .vec_rd(vec_rd), .rdata(bus_rdata), .ack(bus_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (|(flag_d & mask_d)) & ~vec_rd;
  end
  assign irq_o = irq_q;

  // R9: request gap after each vector read
  p_irq_gap_r9: assert property (@(posedge clk) disable iff (rst)
    vec_rd |=> !irq_o);

  // R5: request tracks enabled pending bits otherwise
  p_irq_follow_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(vec_rd) |-> (irq_o == (|(flag_q & mask_q))));

  // R6: grant is a single enabled source with nothing enabled below it
  p_grant_prio_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~enabled) == '0) &&
    (((grant - 1'b1) & enabled) == '0));

  // R6: code is zero exactly when nothing enabled is pending
  p_code_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (vec_code == '0) == (enabled == '0));

endmodule

// File: tb/test_irq_group_ctrl.sv
module test_irq_group_ctrl;

  localparam int N = 16;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] evt_i = '0;
  logic         bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         bus_ack, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_group_ctrl #(.NUM_SRC(N), .DATA_W(W)) i_irq_group_ctrl (
    .clk(clk), .rst(rst), .evt_i(evt_i), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one access, optional same-cycle events; samples the cycle after
  task automatic access(input logic we, input logic [1:0] addr, input logic [W-1:0] wd,
                        input logic [N-1:0] ev, output logic [W-1:0] rd,
                        output logic irq_after, output logic ack_after);
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd; evt_i = ev;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; evt_i = '0;
    rd = bus_rdata; irq_after = irq_o; ack_after = bus_ack;
  endtask

  task automatic pulse(input logic [N-1:0] ev);
    @(negedge clk); evt_i = ev;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [W-1:0] d);
    logic i, k;
    access(1'b0, a, '0, '0, d, i, k);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [W-1:0] d);
    logic [W-1:0] r; logic i, k;
    access(1'b1, a, d, '0, r, i, k);
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    chk("R1 irq", irq_o, 0);
    chk("R1 ack", bus_ack, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd_reg(2'd0, d); chk("R1 pending", d, 0);
    rd_reg(2'd1, d); chk("R1 mask", d, 0);
    rd_reg(2'd2, d); chk("R1 vector", d, 0);
  endtask

  task automatic t_set_and_masked();
    logic [W-1:0] d;
    pulse(16'h0008);
    rd_reg(2'd0, d); chk("R2 pending set", d, 16'h0008);
    chk("R5 masked no irq", irq_o, 0);
    rd_reg(2'd2, d); chk("R5 masked vector", d, 0);
    rd_reg(2'd0, d); chk("R7 empty read clears nothing", d, 16'h0008);
  endtask

  task automatic t_w1c();
    logic [W-1:0] d, r; logic i, k;
    pulse(16'h00F0);
    wr_reg(2'd0, 16'h0030);
    rd_reg(2'd0, d); chk("R3 partial clear", d, 16'h00C8);
    wr_reg(2'd0, 16'hFFFF);
    rd_reg(2'd0, d); chk("R3 clear all", d, 0);
    access(1'b1, 2'd0, 16'h0020, 16'h0020, r, i, k);
    rd_reg(2'd0, d); chk("R4 set beats clear", d, 16'h0020);
    wr_reg(2'd0, 16'hFFFF);
  endtask

  task automatic t_priority();
    logic [W-1:0] d; logic i, k;
    wr_reg(2'd1, 16'hFFFF);
    rd_reg(2'd1, d); chk("R5 mask readback", d, 16'hFFFF);
    pulse(16'h8410);
    chk("R5 irq raised", irq_o, 1);
    access(1'b0, 2'd2, '0, '0, d, i, k);
    chk("R6 vector index4", d, 5);
    chk("R9 gap", i, 0);
    chk("R11 read ack", k, 1);
    @(negedge clk);
    chk("R9 reassert", irq_o, 1);
    chk("R11 ack one cycle", bus_ack, 0);
    rd_reg(2'd0, d); chk("R7 only granted cleared", d, 16'h8400);
    rd_reg(2'd2, d); chk("R6 vector index10", d, 11);
    rd_reg(2'd2, d); chk("R6 vector index15", d, 16);
    access(1'b0, 2'd2, '0, '0, d, i, k);
    chk("R6 empty vector", d, 0);
    @(negedge clk);
    chk("R5 irq idle", irq_o, 0);
  endtask

  task automatic t_mask();
    logic [W-1:0] d;
    wr_reg(2'd1, 16'h0002);
    pulse(16'h0003);
    rd_reg(2'd2, d); chk("R5 masked lower index skipped", d, 2);
    rd_reg(2'd0, d); chk("R7 masked flag kept", d, 16'h0001);
    chk("R5 irq low when only masked", irq_o, 0);
    wr_reg(2'd0, 16'hFFFF);
  endtask

  task automatic t_hazard();
    logic [W-1:0] d; logic i, k;
    wr_reg(2'd1, 16'hFFFF);
    pulse(16'h0200);
    access(1'b0, 2'd2, '0, 16'h0004, d, i, k);
    chk("R8 returns lower source", d, 10);
    rd_reg(2'd0, d); chk("R8 higher event kept", d, 16'h0004);
    rd_reg(2'd2, d); chk("R8 higher served next", d, 3);
  endtask

  task automatic t_vec_write();
    logic [W-1:0] d, r; logic i, k;
    wr_reg(2'd1, 16'h00FF);
    pulse(16'h0040);
    access(1'b1, 2'd2, 16'hFFFF, '0, r, i, k);
    chk("R11 write ack", k, 1);
    rd_reg(2'd2, d); chk("R10 vector unchanged", d, 7);
    rd_reg(2'd1, d); chk("R10 mask unchanged", d, 16'h00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_set_and_masked();
    t_w1c();
    t_priority();
    t_mask();
    t_hazard();
    t_vec_write();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule